// File: doc/BRIEF.md
# Programmable Duty Card Clock Divider

This block turns a fast reference clock into the core clock of a card host controller. A configuration word sets the length of each output period, in reference cycles, and how many of those cycles the output stays high. The same period counter also produces three one-cycle strobes. Each strobe marks a programmable reference-cycle offset inside the period. The strobes serve as the launch point for outgoing data, the capture point for incoming data and the reference edge for core logic.

With a 160 MHz reference, the period field covers 1 to 15, so the output runs from 10 MHz to 80 MHz. A zero period field parks the clock and every strobe low. A new configuration word is picked up only where one period ends and the next begins. Software can therefore rewrite the word at any moment and never get a shortened pulse.

The configuration word is a plain control input with no handshake. It is sampled on every reference edge, and only the sample taken at a period boundary matters.

Top module: `cclk_divgen`

## Requirements
- R1: With period field P = `cfg_word[3:0]` nonzero, successive rising edges of `card_clk` are exactly P + 1 reference cycles apart.
- R2: With high field H = `cfg_word[7:4]` below P, `card_clk` stays high for H + 1 reference cycles at the start of each period and is low for the rest.
- R3: With H greater than or equal to P, `card_clk` is high for P cycles and low only in the last reference cycle of the period.
- R4: P = 3 with H = 1 gives a four-cycle period with two cycles high and two low (40 MHz at 50% duty from a 160 MHz reference).
- R5: A period field of zero (including the all-zero word), once taken up at a boundary, holds `card_clk` and all three strobes low, whatever the other fields hold.
- R6: A word changed in the middle of a period leaves that period's length, high time and strobe positions untouched; the new values govern from the next period on.
- R7: Strobes come from launch `cfg_word[11:8]`, sample `cfg_word[15:12]` and core `cfg_word[19:16]`. Each pulses for exactly one reference cycle per period, at offset (field mod (P + 1)) counted from the rising-edge cycle of `card_clk` as offset 0.
- R8: While `rst_n` is low, `card_clk` and all strobes are low.
- R9: When a nonzero period field is taken up from the stopped state, `card_clk` is high in the very next cycle, which opens a fresh period at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 20 | Period, high-time and three phase fields, 4 bits each |
| card_clk | output | 1 | Divided clock, registered |
| strb_launch | output | 1 | One-cycle strobe at the data-out launch offset |
| strb_sample | output | 1 | One-cycle strobe at the data-in sampling offset |
| strb_core | output | 1 | One-cycle strobe at the core offset |

## Verification
The bound checker looks at every cycle. It checks the spacing of rising edges against the period in force and the high run against the high field, saturated for oversized values. It checks that each strobe falls on its wrapped offset, that a stopped generator is quiet, and that a restart opens with a high cycle. Some behaviours can only be shown by the bench's scenarios. These are the exact durations seen for chosen words, including the 40 MHz half-duty setting and phase values that must wrap. They also include a rewrite a few cycles into a long period, where the old period must finish unchanged before the new one appears. The last is a stop with non-zero side fields, which must stay silent.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int NUM_PH = 3;
  typedef enum int {
    PH_LAUNCH = 0,
    PH_SAMPLE = 1,
    PH_CORE   = 2
  } ph_sel_e;
endpackage

// File: rtl/cclk_cfg_stage.sv
// Active configuration registers; loaded only when the counter wraps
// or the generator is stopped. Phases are reduced modulo (P+1) on load.
module cclk_cfg_stage
  import cclk_pkg::*;
#(
  parameter int FW  = 4,
  parameter int NPH = NUM_PH,
  localparam int CW = (2 + NPH) * FW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            cfg_word,
  input  logic                     load,
  output logic [FW-1:0]            p_nxt,
  output logic [FW-1:0]            h_nxt,
  output logic [NPH-1:0][FW-1:0]   ph_nxt,
  output logic [FW-1:0]            p_q,
  output logic [FW-1:0]            h_q,
  output logic [NPH-1:0][FW-1:0]   ph_q
);
  logic [FW-1:0] cfg_p;
  logic [FW-1:0] cfg_h;
  logic [FW:0]   wrap_den;

  assign cfg_p    = cfg_word[FW-1:0];
  assign cfg_h    = cfg_word[2*FW-1:FW];
  assign wrap_den = {1'b0, cfg_p} + {{FW{1'b0}}, 1'b1};

  assign p_nxt = load ? cfg_p : p_q;
  assign h_nxt = load ? cfg_h : h_q;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic [FW:0] raw_ph;
    logic [FW:0] red_ph;
    assign raw_ph    = {1'b0, cfg_word[(2+i)*FW +: FW]};
    assign red_ph    = raw_ph % wrap_den;
    assign ph_nxt[i] = load ? red_ph[FW-1:0] : ph_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= '0;
      h_q  <= '0;
      ph_q <= '0;
    end else begin
      p_q  <= p_nxt;
      h_q  <= h_nxt;
      ph_q <= ph_nxt;
    end
  end
endmodule

// File: rtl/cclk_counter.sv
// Position counter within the period; wrap marks the period boundary.
module cclk_counter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] p_q,
  output logic [FW-1:0] cnt_nxt,
  output logic          wrap
);
  logic [FW-1:0] cnt_q;

  assign wrap    = (p_q == '0) || (cnt_q == p_q);
  assign cnt_nxt = wrap ? '0 : cnt_q + FW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cclk_wave.sv
// Registered clock output, decided from next-state position and config.
module cclk_wave #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] cnt_nxt,
  input  logic [FW-1:0] p_nxt,
  input  logic [FW-1:0] h_nxt,
  output logic          clk_q
);
  logic hi_nxt;

  // High from position 0 through H, never in the last position of a period.
  assign hi_nxt = (p_nxt != '0) && (cnt_nxt <= h_nxt) && (cnt_nxt != p_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= hi_nxt;
  end
endmodule

// File: rtl/cclk_strobe.sv
// One-cycle phase strobe at a wrapped offset within the period.
module cclk_strobe #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] cnt_nxt,
  input  logic [FW-1:0] p_nxt,
  input  logic [FW-1:0] ph_nxt,
  output logic          strb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= (p_nxt != '0) && (cnt_nxt == ph_nxt);
  end
endmodule

// File: rtl/cclk_divgen.sv
module cclk_divgen
  import cclk_pkg::*;
#(
  parameter int  FW    = 4,
  localparam int CFG_W = (2 + NUM_PH) * FW
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             card_clk,
  output logic             strb_launch,
  output logic             strb_sample,
  output logic             strb_core
);
  logic [FW-1:0]             p_nxt, h_nxt, p_q, h_q;
  logic [NUM_PH-1:0][FW-1:0] ph_nxt, ph_q;
  logic [FW-1:0]             cnt_nxt;
  logic                      wrap;
  logic [NUM_PH-1:0]         strb_vec;

  cclk_counter #(.FW(FW)) u_cnt (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .p_q     (p_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  cclk_cfg_stage #(.FW(FW), .NPH(NUM_PH)) u_cfg (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .load     (wrap),
    .p_nxt    (p_nxt),
    .h_nxt    (h_nxt),
    .ph_nxt   (ph_nxt),
    .p_q      (p_q),
    .h_q      (h_q),
    .ph_q     (ph_q)
  );

  cclk_wave #(.FW(FW)) u_wave (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .cnt_nxt (cnt_nxt),
    .p_nxt   (p_nxt),
    .h_nxt   (h_nxt),
    .clk_q   (card_clk)
  );

  for (genvar i = 0; i < NUM_PH; i++) begin : g_strb
    cclk_strobe #(.FW(FW)) u_strb (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt),
      .p_nxt   (p_nxt),
      .ph_nxt  (ph_nxt[i]),
      .strb_q  (strb_vec[i])
    );
  end

  assign strb_launch = strb_vec[PH_LAUNCH];
  assign strb_sample = strb_vec[PH_SAMPLE];
  assign strb_core   = strb_vec[PH_CORE];
endmodule

// File: rtl/cclk_divgen_chk.sv
module cclk_divgen_chk #(
  parameter int  FW  = 4,
  parameter int  NPH = 3,
  localparam int SW  = FW + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   card_clk,
  input logic [NPH-1:0]         strb,
  input logic [FW-1:0]          act_p,
  input logic [FW-1:0]          act_h,
  input logic [NPH-1:0][FW-1:0] act_ph
);
  logic          prev_clk, have_prev;
  logic [FW-1:0] p_prev;
  logic [SW-1:0] since, hi_run, pos, hi_exp;
  logic          rise_now, fall_now;

  assign rise_now = card_clk && !prev_clk;
  assign fall_now = !card_clk && prev_clk;
  assign pos      = rise_now ? '0 : since;
  assign hi_exp   = (act_h >= act_p) ? SW'(act_p) : SW'(act_h) + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk  <= 1'b0;
      have_prev <= 1'b0;
      p_prev    <= '0;
      since     <= '0;
      hi_run    <= '0;
    end else begin
      prev_clk <= card_clk;
      p_prev   <= act_p;
      if (act_p == '0)   have_prev <= 1'b0;
      else if (rise_now) have_prev <= 1'b1;
      if (rise_now)            since <= SW'(1);
      else if (since != '1)    since <= since + SW'(1);
      if (rise_now)            hi_run <= SW'(1);
      else if (card_clk && hi_run != '1) hi_run <= hi_run + SW'(1);
    end
  end

  a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && have_prev) |-> (since == SW'(p_prev) + SW'(1)));

  // Covers R2 and R3: high run length, saturated when H >= P.
  a_r2_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_now && act_p != '0) |-> (hi_run == hi_exp));

  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act_p == '0) |-> (!card_clk && strb == '0));

  a_r9_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (p_prev == '0 && act_p != '0) |-> card_clk);

  for (genvar i = 0; i < NPH; i++) begin : g_r7
    a_r7_strobe_pos: assert property (@(posedge clk) disable iff (!rst_n)
      strb[i] |-> (pos == SW'(act_ph[i])));
  end
endmodule

bind cclk_divgen cclk_divgen_chk #(.FW(FW), .NPH(cclk_pkg::NUM_PH)) chk_i (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .card_clk (card_clk),
  .strb     (strb_vec),
  .act_p    (p_q),
  .act_h    (h_q),
  .act_ph   (ph_q)
);

// File: tb/cclk_divgen_tb_top.sv
module cclk_divgen_tb_top;
  localparam int FW    = 4;
  localparam int CFG_W = 5 * FW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic             card_clk, s_l, s_s, s_c;

  always #4 clk = ~clk;

  cclk_divgen #(.FW(FW)) dut_i (
    .clk_ref     (clk),
    .rst_n       (rst_n),
    .cfg_word    (cfg),
    .card_clk    (card_clk),
    .strb_launch (s_l),
    .strb_sample (s_s),
    .strb_core   (s_c)
  );

  typedef struct {
    int    per;
    int    hi;
    int    pos[3];
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk(input int p, input int h,
                                          input int a, input int b, input int c);
    return {FW'(c), FW'(b), FW'(a), FW'(h), FW'(p)};
  endfunction

  // Expected period shape straight from R1..R3 and R7.
  function automatic exp_t mk_exp(input int p, input int h, input int a,
                                  input int b, input int c, input string tag);
    exp_t e;
    e.per    = p + 1;
    e.hi     = (h >= p) ? p : h + 1;
    e.pos[0] = a % (p + 1);
    e.pos[1] = b % (p + 1);
    e.pos[2] = c % (p + 1);
    e.tag    = tag;
    return e;
  endfunction

  task automatic apply(input int p, input int h, input int a, input int b, input int c);
    @(negedge clk);
    cfg = mk(p, h, a, b, c);
    repeat (40) @(negedge clk);
  endtask

  task automatic push_n(input int p, input int h, input int a, input int b,
                        input int c, input int n, input string tag);
    for (int k = 0; k < n; k++) q.push_back(mk_exp(p, h, a, b, c, tag));
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: measures each period from rising edge to rising edge.
  bit prev_c = 0;
  bit rec_on = 0;
  int pos_n, hi_n;
  int scnt[3];
  int spos[3];

  always @(negedge clk) begin
    logic [2:0] sv;
    sv = {s_c, s_s, s_l};
    if (!rst_n) begin
      prev_c = 0;
      rec_on = 0;
    end else begin
      if (card_clk && !prev_c) begin
        if (rec_on && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          chk(pos_n == e.per, {e.tag, " R1"}, "period", pos_n, e.per);
          chk(hi_n == e.hi, {e.tag, " R2/R3"}, "high time", hi_n, e.hi);
          for (int i = 0; i < 3; i++) begin
            chk(scnt[i] == 1, {e.tag, " R7"}, $sformatf("strobe%0d count", i), scnt[i], 1);
            chk(spos[i] == e.pos[i], {e.tag, " R7"}, $sformatf("strobe%0d offset", i),
                spos[i], e.pos[i]);
          end
        end
        rec_on = (q.size() > 0);
        pos_n  = 0;
        hi_n   = 0;
        for (int i = 0; i < 3; i++) begin
          scnt[i] = 0;
          spos[i] = -1;
        end
      end
      if (rec_on) begin
        if (card_clk) hi_n++;
        for (int i = 0; i < 3; i++) begin
          if (sv[i]) begin
            scnt[i]++;
            spos[i] = pos_n;
          end
        end
        pos_n++;
      end
      prev_c = card_clk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int act;
    bit pv;
    // R8: reset state
    repeat (5) @(negedge clk);
    chk(card_clk == 1'b0, "R8", "clock in reset", int'(card_clk), 0);
    chk({s_l, s_s, s_c} == 3'b000, "R8", "strobes in reset", int'({s_l, s_s, s_c}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(card_clk == 1'b0, "R5", "all-zero word after reset", int'(card_clk), 0);

    // R4: 40 MHz half duty, phases 4/4/0 wrap to 0
    apply(3, 1, 4, 4, 0);
    @(posedge clk); #1;
    push_n(3, 1, 4, 4, 0, 3, "R4");
    drain();

    // R1 R2 R7: plain pattern
    apply(7, 2, 1, 5, 7);
    @(posedge clk); #1;
    push_n(7, 2, 1, 5, 7, 2, "R2");
    drain();

    // R3: high field above period, phases wrap
    apply(5, 9, 9, 12, 15);
    @(posedge clk); #1;
    push_n(5, 9, 9, 12, 15, 2, "R3");
    drain();

    // R1 R7: shortest period, phases wrap modulo 2
    apply(1, 0, 4, 5, 0);
    @(posedge clk); #1;
    push_n(1, 0, 4, 5, 0, 3, "R1");
    drain();

    // R3: longest period, H equal to P
    apply(15, 15, 15, 0, 8);
    @(posedge clk); #1;
    push_n(15, 15, 15, 0, 8, 2, "R3");
    drain();

    // R6: rewrite three cycles into a long period
    @(posedge clk); #1;
    push_n(15, 15, 15, 0, 8, 1, "R6");
    push_n(3, 1, 4, 4, 0, 2, "R6");
    pv = card_clk;
    forever begin
      @(negedge clk);
      if (card_clk && !pv) break;
      pv = card_clk;
    end
    repeat (3) @(negedge clk);
    cfg = mk(3, 1, 4, 4, 0);
    drain();

    // R5: all-zero word stops everything
    apply(0, 0, 0, 0, 0);
    act = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      act += int'(card_clk) + int'(s_l) + int'(s_s) + int'(s_c);
    end
    chk(act == 0, "R5", "activity with zero word", act, 0);

    // R5: zero period with other fields set still stops
    apply(0, 5, 3, 2, 1);
    act = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      act += int'(card_clk) + int'(s_l) + int'(s_s) + int'(s_c);
    end
    chk(act == 0, "R5", "activity with zero period", act, 0);

    // R9: restart opens with a high cycle at offset 0
    @(negedge clk);
    cfg = mk(2, 0, 1, 2, 0);
    @(negedge clk);
    chk(card_clk == 1'b1, "R9", "clock first cycle after restart", int'(card_clk), 1);
    chk(s_c == 1'b1, "R9", "core strobe at offset 0", int'(s_c), 1);
    repeat (10) @(negedge clk);
    @(posedge clk); #1;
    push_n(2, 0, 1, 2, 0, 2, "R9");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule